// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from a fast reference clock. The divisor is not a free-form count: a 4-bit modulus M sets a half period of 2×(M+1) reference ticks, so one serial period lasts 4×(M+1) reference cycles, and a divide-by-16 option stretches every tick to sixteen reference cycles for a total divisor of 64×(M+1). A polarity input chooses whether the clock rests low or high.

Alongside the clock level the block emits two one-cycle strobes, one on the cycle the clock leaves its resting level and one on the cycle it returns, so a neighbouring shift register can launch and capture data without looking at the clock itself. The mode inputs are only taken while the controller enable is low; while enabled they are held, and a new setting becomes effective when the enable rises again. Dropping either enable or run returns the clock to rest on the next cycle and restarts the timing.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: With the divide-by-16 input low, the first leading strobe comes 2×(M+1) reference cycles after run and enable are both seen high, and every later clock edge follows the previous one after 2×(M+1) cycles.
- R2: With the divide-by-16 input high, every one of those intervals is 32×(M+1) reference cycles.
- R3: The high and low halves of a serial period are equal, so successive leading strobes are 4×(M+1) (or 64×(M+1)) cycles apart.
- R4: While the controller is not running the clock output sits at the polarity level (0 rests low, 1 rests high); while the clock is in its active half it shows the inverse level.
- R5: The leading strobe is high for exactly the first cycle in which the clock shows the active level, the trailing strobe for exactly the first cycle back at the resting level, and the two are never high together.
- R6: While enable is high the modulus, divide-by-16 and polarity inputs are ignored; the values present while enable was low are the ones used after it rises.
- R7: When run or enable goes low, on the next cycle the clock is at its resting level and both strobes are low, and a new run starts the full first half again.
- R8: The asynchronous active-low reset forces the clock low, both strobes low, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; mode inputs load while low |
| run_i | input | 1 | Request to generate the serial clock |
| pm_i | input | 4 | Prescale modulus M |
| div16_i | input | 1 | Extra divide-by-16 pre-stage |
| cpol_i | input | 1 | Resting level of the serial clock |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on the clock leaving rest |
| trail_o | output | 1 | One-cycle strobe on the clock returning to rest |

## Verification
The awkward situation is a mode change that arrives while the controller is enabled, since from the ports it can only be seen as timing that did not change. The stimulus therefore drives the inverted modulus, divide and polarity in the very cycle enable rises and keeps them scrambled through the whole measurement, so any leak shows up as a wrong interval or level. Restart after a mid-half run drop is driven directly, and random moduli with occasional divide-by-16 cover the span of divisors.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  parameter int PM_W = 4;

  typedef struct packed {
    logic            cpol;
    logic            div16;
    logic [PM_W-1:0] pm;
  } sclk_cfg_t;
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  sclk_cfg_t cfg_i,
  output sclk_cfg_t cfg_o
);
  sclk_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
  parameter int PRE_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic div_en_i,
  output logic tick_o
);
  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!active_i)          cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign tick_o = active_i & (div_en_i ? (cnt_q == LAST) : 1'b1);
    end else begin : g_nopre
      logic unused_div;
      assign unused_div = div_en_i ^ clk_i ^ rst_ni;
      assign tick_o = active_i;
    end
  endgenerate
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int PM_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            tick_i,
  input  logic [PM_W-1:0] pm_i,
  output logic            phase_o,
  output logic            lead_o,
  output logic            trail_o
);
  localparam int HC_W = PM_W + 1;

  logic [HC_W-1:0] hc_q, hc_d;
  logic            phase_q, phase_d;
  logic            lead_q, lead_d;
  logic            trail_q, trail_d;
  logic            term;

  // half length 2*(pm+1) ticks, last count value is 2*pm+1
  assign term = tick_i && (hc_q == {pm_i, 1'b1});

  always_comb begin
    hc_d    = hc_q;
    phase_d = phase_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!active_i) begin
      hc_d    = '0;
      phase_d = 1'b0;
    end else if (tick_i) begin
      if (term) begin
        hc_d    = '0;
        phase_d = ~phase_q;
        lead_d  = ~phase_q;
        trail_d = phase_q;
      end else begin
        hc_d = hc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q    <= '0;
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      hc_q    <= hc_d;
      phase_q <= phase_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign phase_o = phase_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import sclk_pkg::*;
#(
  parameter int PRE_DIV = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            run_i,
  input  logic [PM_W-1:0] pm_i,
  input  logic            div16_i,
  input  logic            cpol_i,
  output logic            sclk_o,
  output logic            lead_o,
  output logic            trail_o
);
  sclk_cfg_t cfg_in, cfg;
  logic      active, tick, phase;

  assign cfg_in = '{cpol: cpol_i, div16: div16_i, pm: pm_i};
  assign active = enable_i & run_i;

  sclk_cfg_hold u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~enable_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg)
  );

  sclk_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .div_en_i (cfg.div16),
    .tick_o   (tick)
  );

  sclk_half_timer #(.PM_W(PM_W)) u_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (tick),
    .pm_i     (cfg.pm),
    .phase_o  (phase),
    .lead_o   (lead_o),
    .trail_o  (trail_o)
  );

  assign sclk_o = cfg.cpol ^ phase;
endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic run_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  assert_lead_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != $past(sclk_o)));

  assert_trail_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o != $past(sclk_o)));

  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (sclk_o == $past(cpol_i)));

  assert_stop_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_i && run_i) |=> (!lead_o && !trail_o));

  assert_edge_has_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i && run_i) && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o));
endmodule

bind spi_sclk_prescaler sclk_prescaler_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .run_i    (run_i),
  .cpol_i   (cpol_i),
  .sclk_o   (sclk_o),
  .lead_o   (lead_o),
  .trail_o  (trail_o)
);

// File: tb/spi_sclk_prescaler_tb_top.sv
module spi_sclk_prescaler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 4000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       enable_i, run_i, div16_i, cpol_i;
  logic [3:0] pm_i;
  logic       sclk_o, lead_o, trail_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_sclk_prescaler dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .run_i    (run_i),
    .pm_i     (pm_i),
    .div16_i  (div16_i),
    .cpol_i   (cpol_i),
    .sclk_o   (sclk_o),
    .lead_o   (lead_o),
    .trail_o  (trail_o)
  );

  function automatic int half_len(input int pm, input bit div);
    return 2 * (pm + 1) * (div ? 16 : 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(input bit want_lead, output int n);
    n = 0;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk_i);
      n++;
      if (want_lead ? lead_o : trail_o) break;
    end
  endtask

  task automatic run_case(input int pm, input bit div, input bit pol);
    int n, h;
    h = half_len(pm, div);
    @(negedge clk_i);
    enable_i = 1'b0; run_i = 1'b0;
    pm_i = 4'(pm); div16_i = div; cpol_i = pol;
    @(negedge clk_i);
    @(negedge clk_i);
    check(sclk_o == pol, "R4 idle", sclk_o, pol);
    enable_i = 1'b1; run_i = 1'b1;
    // R6: scramble mode inputs while enabled
    pm_i = ~4'(pm); div16_i = ~div; cpol_i = ~pol;
    wait_strobe(1'b1, n);
    check(n == h, div ? "R2 first lead" : "R1 first lead", n, h);
    check(sclk_o == !pol && !trail_o, "R5 lead level", sclk_o, !pol);
    wait_strobe(1'b0, n);
    check(n == h, "R3 high half", n, h);
    check(sclk_o == pol, "R5 trail level", sclk_o, pol);
    wait_strobe(1'b1, n);
    check(n == h, "R3 low half", n, h);
    run_i = 1'b0;
    @(negedge clk_i);
    check(sclk_o == pol && !lead_o && !trail_o, "R7 stop", sclk_o, pol);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5c1c));
    rst_ni = 1'b0; enable_i = 1'b0; run_i = 1'b0;
    pm_i = 4'hF; div16_i = 1'b1; cpol_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(sclk_o == 1'b0 && !lead_o && !trail_o, "R8 reset", sclk_o, 0);
    rst_ni = 1'b1;

    run_case(0, 1'b0, 1'b0);
    run_case(15, 1'b0, 1'b1);
    run_case(0, 1'b1, 1'b1);
    run_case(15, 1'b1, 1'b0);

    // R7: drop run mid-half, restart must begin a full first half
    @(negedge clk_i);
    enable_i = 1'b0; pm_i = 4'd3; div16_i = 1'b0; cpol_i = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1; run_i = 1'b1;
    repeat (5) @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    check(sclk_o == 1'b0 && !lead_o, "R7 mid drop", sclk_o, 0);
    run_i = 1'b1;
    wait_strobe(1'b1, n);
    check(n == 8, "R7 restart", n, 8);
    run_i = 1'b0;

    for (int k = 0; k < 24; k++) begin
      run_case(int'($urandom % 16), ($urandom % 4) == 0, 1'(($urandom % 2)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule